// File: doc/BRIEF.md
# Debug Port Pin Release Controller

This block decides, for five shared pads, whether each one belongs to a combined JTAG / serial-wire debug port or to the general-purpose I/O controller. Software writes a small mode register that picks one of four port-enable modes and can turn on the asynchronous trace output. The block then steers each pad's output data, output enable, pull-up, pull-down and input-buffer enable from the debug side or the GPIO side. It also drives the input signals that the debug logic in the core sees.

Pins are never handed over in a single step. When a mode change takes a pad away from the debug port, the core-side debug input for that pad is first forced to a safe constant level. Pad control moves to the GPIO controller only on the next clock edge. When a pad is given back to the debug port, pad ownership returns first, and the constant is removed one edge later. As a result the debug logic never sees an undriven input.

If the bus bridge write buffer is full when a write that releases pins is accepted, the block raises a wait flag for one cycle. The bus interface uses this flag to add the extra cycle that the handover needs.

Top module: `dbg_pad_release_ctrl`

## Requirements
- R1: After reset, all five pads are owned by the debug port and no core-side input is forced. The mode is 0, trace is off, and `cfg_rd_data` reads 4'h0.
- R2: `cfg_wr_data[2:0]` selects the mode and `cfg_wr_data[3]` turns on trace. The pad indices are: 0 test mode select / serial-wire data, 1 test clock / serial-wire clock, 2 test data in, 3 test data out / trace, 4 test reset. The debug-owned pad sets are: mode 0 all pads; mode 1 pads 0-3; mode 2 pads 0 and 1; mode 3 none.
- R3: A mode code of 4 to 7 behaves exactly like mode 3. The register then reads back 3 in `cfg_rd_data[2:0]`.
- R4: On the clock edge that accepts a write, every pad that the new mode releases has its core-side input forced. On the following edge that pad's controls switch to the GPIO side.
- R5: On the clock edge that accepts a write, every pad that the new mode gives back to the debug port returns to debug ownership. Its core-side force is removed on the following edge.
- R6: The forced core-side levels are 1 for test mode select, 0 for test clock, 1 for test data in and 1 for test reset.
- R7: `cfg_wait` is high for exactly the one cycle after a write that is accepted while `cfg_wbuf_full` is high and that releases at least one debug-owned pad. In every other case it stays low.
- R8: When trace is on and pad 3 is debug-owned, pad 3 drives `dbg_swo_out` with its output enable at 1. When trace is off and pad 3 is debug-owned, pad 3 drives `dbg_tdo_out` with `dbg_tdo_oe`.
- R9: A GPIO-owned pad follows `gpio_out`, `gpio_oe`, `gpio_pu`, `gpio_pd` and `gpio_ie`. `gpio_in` shows `pad_in` for GPIO-owned pads and shows 0 for debug-owned pads.
- R10: A debug-owned pad has a pull-up on pads 0, 2 and 4 and a pull-down on pad 1. It never has both a pull-up and a pull-down. Its input buffer is on for every pad except pad 3. Pad 0 drives `dbg_swdio_out` with `dbg_swdio_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Mode register write strobe |
| cfg_wr_data | input | 4 | Write data: [2:0] mode, [3] trace enable |
| cfg_wbuf_full | input | 1 | Bus bridge write buffer is full |
| cfg_wait | output | 1 | One-cycle wait request for the bus |
| cfg_rd_data | output | 4 | Mode and trace setting in effect |
| dbg_swdio_out | input | 1 | Serial-wire data out from debug logic |
| dbg_swdio_oe | input | 1 | Serial-wire data direction from debug logic |
| dbg_tdo_out | input | 1 | Test data out from debug logic |
| dbg_tdo_oe | input | 1 | Test data out enable |
| dbg_swo_out | input | 1 | Asynchronous trace output |
| core_tms_swdio | output | 1 | Core-side test mode select / serial-wire data in |
| core_tck_swclk | output | 1 | Core-side test / serial-wire clock |
| core_tdi | output | 1 | Core-side test data in |
| core_trst_n | output | 1 | Core-side test reset |
| gpio_out | input | 5 | GPIO output data per pad |
| gpio_oe | input | 5 | GPIO output enable per pad |
| gpio_pu | input | 5 | GPIO pull-up per pad |
| gpio_pd | input | 5 | GPIO pull-down per pad |
| gpio_ie | input | 5 | GPIO input buffer enable per pad |
| gpio_in | output | 5 | Pad input seen by GPIO |
| pad_in | input | 5 | Pad input level |
| pad_out | output | 5 | Pad output data |
| pad_oe | output | 5 | Pad output enable |
| pad_pu | output | 5 | Pad pull-up |
| pad_pd | output | 5 | Pad pull-down |
| pad_ie | output | 5 | Pad input buffer enable |

## Verification
The hardest cycle to observe is the middle cycle of a handover. In that cycle a released pad still has debug pad control while its core-side input is already forced, or a returned pad is debug-owned while its force is still on. The stimulus makes both states visible. It drives `pad_in` to the complement of every forced level, so a forced input shows up directly on the core-side outputs. It also drives both GPIO pulls high on every pad, so any pad showing pull-up and pull-down together is GPIO-owned. Writes are issued one at a time, and each write produces a two-entry expectation for the two cycles that follow it. The write sequence walks from full debug through every release step down to no debug pads, then returns in one step, then uses an unused mode code.

// File: rtl/dbg_pad_pkg.sv
package dbg_pad_pkg;
  localparam int NPAD   = 5;
  localparam int MODE_W = 3;
  localparam int CFG_W  = MODE_W + 1;

  localparam int P_TMS  = 0;
  localparam int P_TCK  = 1;
  localparam int P_TDI  = 2;
  localparam int P_TDO  = 3;
  localparam int P_TRST = 4;

  typedef enum logic [MODE_W-1:0] {
    M_FULL    = 3'd0,
    M_NO_TRST = 3'd1,
    M_SW_ONLY = 3'd2,
    M_NONE    = 3'd3
  } pad_mode_e;

  localparam logic [NPAD-1:0] FORCE_VAL = 5'b10101;
  localparam logic [NPAD-1:0] DBG_PU    = 5'b10101;
  localparam logic [NPAD-1:0] DBG_PD    = 5'b00010;
  localparam logic [NPAD-1:0] DBG_IE    = 5'b10111;

  function automatic pad_mode_e legalize(input logic [MODE_W-1:0] code);
    pad_mode_e m;
    case (code)
      3'd0:    m = M_FULL;
      3'd1:    m = M_NO_TRST;
      3'd2:    m = M_SW_ONLY;
      default: m = M_NONE;
    endcase
    return m;
  endfunction

  function automatic logic [NPAD-1:0] keep_mask(input pad_mode_e m);
    logic [NPAD-1:0] k;
    case (m)
      M_FULL:    k = 5'b11111;
      M_NO_TRST: k = 5'b01111;
      M_SW_ONLY: k = 5'b00011;
      default:   k = 5'b00000;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/dbg_pad_mode_reg.sv
module dbg_pad_mode_reg
  import dbg_pad_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             wbuf_full,
  input  logic [NPAD-1:0]  own_q,
  output logic [NPAD-1:0]  keep_nx,
  output logic             trace_q,
  output logic             wait_q,
  output logic [CFG_W-1:0] rd_data
);
  pad_mode_e mode_q, mode_nx;
  logic      trace_nx, wait_nx, releases;

  always_comb begin
    mode_nx  = mode_q;
    trace_nx = trace_q;
    if (wr_en) begin
      mode_nx  = legalize(wr_data[MODE_W-1:0]);
      trace_nx = wr_data[CFG_W-1];
    end
    keep_nx  = keep_mask(mode_nx);
    releases = |(own_q & ~keep_nx);
    wait_nx  = wr_en & wbuf_full & releases;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_FULL;
      trace_q <= 1'b0;
      wait_q  <= 1'b0;
    end else begin
      mode_q  <= mode_nx;
      trace_q <= trace_nx;
      wait_q  <= wait_nx;
    end
  end

  assign rd_data = {trace_q, mode_q};

  a_r3_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q inside {M_FULL, M_NO_TRST, M_SW_ONLY, M_NONE});
  a_r7_wait_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q |-> $past(wr_en && wbuf_full));
  a_r7_no_wait_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !wait_q);
endmodule

// File: rtl/dbg_pad_handover.sv
module dbg_pad_handover
  import dbg_pad_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPAD-1:0] keep_nx,
  output logic [NPAD-1:0] own_q,
  output logic [NPAD-1:0] force_q
);
  logic [NPAD-1:0] own_nx, force_nx;

  always_comb begin
    for (int i = 0; i < NPAD; i++) begin
      if (keep_nx[i]) begin
        own_nx[i]   = 1'b1;
        force_nx[i] = ~own_q[i];
      end else begin
        own_nx[i]   = own_q[i] & ~force_q[i];
        force_nx[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q   <= '1;
      force_q <= '0;
    end else begin
      own_q   <= own_nx;
      force_q <= force_nx;
    end
  end

  a_r4_never_floating: assert property (@(posedge clk) disable iff (!rst_n)
    (~own_q & ~force_q) == '0);

  for (genvar g = 0; g < NPAD; g++) begin : g_order
    a_r4_release_order: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(own_q[g]) |-> $past(force_q[g]));
    a_r5_return_order: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(force_q[g]) |-> $past(own_q[g]));
  end
endmodule

// File: rtl/dbg_pad_mux.sv
module dbg_pad_mux
  import dbg_pad_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPAD-1:0] own_q,
  input  logic [NPAD-1:0] force_q,
  input  logic            trace_q,
  input  logic            dbg_swdio_out,
  input  logic            dbg_swdio_oe,
  input  logic            dbg_tdo_out,
  input  logic            dbg_tdo_oe,
  input  logic            dbg_swo_out,
  input  logic [NPAD-1:0] gpio_out,
  input  logic [NPAD-1:0] gpio_oe,
  input  logic [NPAD-1:0] gpio_pu,
  input  logic [NPAD-1:0] gpio_pd,
  input  logic [NPAD-1:0] gpio_ie,
  output logic [NPAD-1:0] gpio_in,
  input  logic [NPAD-1:0] pad_in,
  output logic [NPAD-1:0] pad_out,
  output logic [NPAD-1:0] pad_oe,
  output logic [NPAD-1:0] pad_pu,
  output logic [NPAD-1:0] pad_pd,
  output logic [NPAD-1:0] pad_ie,
  output logic [NPAD-1:0] core_in
);
  logic [NPAD-1:0] d_out, d_oe;

  always_comb begin
    d_out = '0;
    d_oe  = '0;
    d_out[P_TMS] = dbg_swdio_out;
    d_oe[P_TMS]  = dbg_swdio_oe;
    d_out[P_TDO] = trace_q ? dbg_swo_out : dbg_tdo_out;
    d_oe[P_TDO]  = trace_q ? 1'b1 : dbg_tdo_oe;
  end

  for (genvar g = 0; g < NPAD; g++) begin : g_pad
    always_comb begin
      if (own_q[g]) begin
        pad_out[g] = d_out[g];
        pad_oe[g]  = d_oe[g];
        pad_pu[g]  = DBG_PU[g];
        pad_pd[g]  = DBG_PD[g];
        pad_ie[g]  = DBG_IE[g];
        gpio_in[g] = 1'b0;
      end else begin
        pad_out[g] = gpio_out[g];
        pad_oe[g]  = gpio_oe[g];
        pad_pu[g]  = gpio_pu[g];
        pad_pd[g]  = gpio_pd[g];
        pad_ie[g]  = gpio_ie[g];
        gpio_in[g] = pad_in[g];
      end
      core_in[g] = force_q[g] ? FORCE_VAL[g] : pad_in[g];
    end

    a_r10_no_dual_pull: assert property (@(posedge clk) disable iff (!rst_n)
      own_q[g] |-> !(pad_pu[g] && pad_pd[g]));
  end

  a_r6_tck_low: assert property (@(posedge clk) disable iff (!rst_n)
    force_q[P_TCK] |-> !core_in[P_TCK]);
  a_r6_trst_high: assert property (@(posedge clk) disable iff (!rst_n)
    force_q[P_TRST] |-> core_in[P_TRST]);
endmodule

// File: rtl/dbg_pad_release_ctrl.sv
module dbg_pad_release_ctrl
  import dbg_pad_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr_en,
  input  logic [3:0]      cfg_wr_data,
  input  logic            cfg_wbuf_full,
  output logic            cfg_wait,
  output logic [3:0]      cfg_rd_data,
  input  logic            dbg_swdio_out,
  input  logic            dbg_swdio_oe,
  input  logic            dbg_tdo_out,
  input  logic            dbg_tdo_oe,
  input  logic            dbg_swo_out,
  output logic            core_tms_swdio,
  output logic            core_tck_swclk,
  output logic            core_tdi,
  output logic            core_trst_n,
  input  logic [4:0]      gpio_out,
  input  logic [4:0]      gpio_oe,
  input  logic [4:0]      gpio_pu,
  input  logic [4:0]      gpio_pd,
  input  logic [4:0]      gpio_ie,
  output logic [4:0]      gpio_in,
  input  logic [4:0]      pad_in,
  output logic [4:0]      pad_out,
  output logic [4:0]      pad_oe,
  output logic [4:0]      pad_pu,
  output logic [4:0]      pad_pd,
  output logic [4:0]      pad_ie
);
  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic [NPAD-1:0] keep_nx, own_q, force_q, core_in;
  logic            trace_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dbg_pad_mode_reg u_mode (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (cfg_wr_en),
    .wr_data   (cfg_wr_data),
    .wbuf_full (cfg_wbuf_full),
    .own_q     (own_q),
    .keep_nx   (keep_nx),
    .trace_q   (trace_q),
    .wait_q    (cfg_wait),
    .rd_data   (cfg_rd_data)
  );

  dbg_pad_handover u_hand (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .keep_nx (keep_nx),
    .own_q   (own_q),
    .force_q (force_q)
  );

  dbg_pad_mux u_mux (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .own_q         (own_q),
    .force_q       (force_q),
    .trace_q       (trace_q),
    .dbg_swdio_out (dbg_swdio_out),
    .dbg_swdio_oe  (dbg_swdio_oe),
    .dbg_tdo_out   (dbg_tdo_out),
    .dbg_tdo_oe    (dbg_tdo_oe),
    .dbg_swo_out   (dbg_swo_out),
    .gpio_out      (gpio_out),
    .gpio_oe       (gpio_oe),
    .gpio_pu       (gpio_pu),
    .gpio_pd       (gpio_pd),
    .gpio_ie       (gpio_ie),
    .gpio_in       (gpio_in),
    .pad_in        (pad_in),
    .pad_out       (pad_out),
    .pad_oe        (pad_oe),
    .pad_pu        (pad_pu),
    .pad_pd        (pad_pd),
    .pad_ie        (pad_ie),
    .core_in       (core_in)
  );

  assign core_tms_swdio = core_in[P_TMS];
  assign core_tck_swclk = core_in[P_TCK];
  assign core_tdi       = core_in[P_TDI];
  assign core_trst_n    = core_in[P_TRST];

  a_r1_reset_owned: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (own_q == '1 && force_q == '0));
endmodule

// File: tb/dbg_pad_release_ctrl_tb_top.sv
module dbg_pad_release_ctrl_tb_top;
  typedef struct {
    logic [4:0] own;
    logic [4:0] frc;
    logic       wt;
    logic [3:0] rd;
    string      tag;
  } item_t;

  localparam logic [4:0] FRC_LVL = 5'b10101;
  localparam logic [4:0] CORE_M  = 5'b10111;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr_en, cfg_wbuf_full, cfg_wait;
  logic [3:0] cfg_wr_data, cfg_rd_data;
  logic dbg_swdio_out, dbg_swdio_oe, dbg_tdo_out, dbg_tdo_oe, dbg_swo_out;
  logic core_tms_swdio, core_tck_swclk, core_tdi, core_trst_n;
  logic [4:0] gpio_out, gpio_oe, gpio_pu, gpio_pd, gpio_ie, gpio_in;
  logic [4:0] pad_in, pad_out, pad_oe, pad_pu, pad_pd, pad_ie;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  item_t sb[$];
  logic [4:0] own_m;

  always #4 clk = ~clk;

  dbg_pad_release_ctrl dut_i (.*);

  function automatic logic [4:0] bench_keep(input logic [2:0] code);
    case (code)
      3'd0: return 5'b11111;
      3'd1: return 5'b01111;
      3'd2: return 5'b00011;
      default: return 5'b00000;
    endcase
  endfunction

  function automatic logic [4:0] seen_own();
    return ~(pad_pu & pad_pd);
  endfunction

  function automatic logic [4:0] seen_force();
    logic [4:0] c;
    c = {core_trst_n, 1'b0, core_tdi, core_tck_swclk, core_tms_swdio};
    return ~(c ^ FRC_LVL) & CORE_M;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: one queued expectation per cycle
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      chk(seen_own() == it.own, it.tag, "ownership", {3'b0, seen_own()}, {3'b0, it.own});
      chk(seen_force() == (it.frc & CORE_M), it.tag, "core force",
          {3'b0, seen_force()}, {3'b0, it.frc & CORE_M});
      chk(cfg_wait == it.wt, "R7", "wait", {7'b0, cfg_wait}, {7'b0, it.wt});
      chk(cfg_rd_data == it.rd, it.tag, "readback", {4'b0, cfg_rd_data}, {4'b0, it.rd});
    end
  end

  // driver: one write, two expectations
  task automatic wr(input logic [3:0] d, input bit full, input string tag);
    logic [2:0] m;
    logic [4:0] k;
    item_t a, b;
    m = (d[2:0] > 3'd3) ? 3'd3 : d[2:0];
    k = bench_keep(m);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = d; cfg_wbuf_full = full;
    @(posedge clk);
    #1;
    a.own = own_m | k;
    a.frc = ~k | (k & ~own_m);
    a.wt  = full && ((own_m & ~k) != 5'b0);
    a.rd  = {d[3], m};
    a.tag = tag;
    b.own = k; b.frc = ~k; b.wt = 1'b0; b.rd = {d[3], m}; b.tag = tag;
    sb.push_back(a);
    sb.push_back(b);
    own_m = k;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_wbuf_full = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_wr_en = 1'b0; cfg_wr_data = 4'h0; cfg_wbuf_full = 1'b0;
    dbg_swdio_out = 1'b0; dbg_swdio_oe = 1'b0;
    dbg_tdo_out = 1'b0; dbg_tdo_oe = 1'b0; dbg_swo_out = 1'b1;
    gpio_out = 5'b00000; gpio_oe = 5'b00000;
    gpio_pu = 5'b11111; gpio_pd = 5'b11111; gpio_ie = 5'b00000;
    pad_in = ~FRC_LVL;
    own_m = 5'b11111;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(seen_own() == 5'b11111, "R1", "owned", {3'b0, seen_own()}, 8'h1f);
    chk(seen_force() == 5'b0, "R1", "force", {3'b0, seen_force()}, 8'h00);
    chk(cfg_rd_data == 4'h0, "R1", "readback", {4'b0, cfg_rd_data}, 8'h00);
    chk(cfg_wait == 1'b0, "R1", "wait", {7'b0, cfg_wait}, 8'h00);
    // R10 debug-owned pad controls
    chk(pad_ie == 5'b10111, "R10", "ie", {3'b0, pad_ie}, 8'h17);
    dbg_swdio_oe = 1'b1; dbg_swdio_out = 1'b1;
    dbg_tdo_out = 1'b1; dbg_tdo_oe = 1'b1; dbg_swo_out = 1'b0;
    @(negedge clk);
    chk(pad_out[0] && pad_oe[0], "R10", "swdio", {6'b0, pad_out[0], pad_oe[0]}, 8'h03);
    // R8 trace off: pad 3 follows test data out
    chk(pad_out[3] && pad_oe[3], "R8", "tdo", {6'b0, pad_out[3], pad_oe[3]}, 8'h03);
    chk(gpio_in == 5'b0, "R9", "gpio_in owned", {3'b0, gpio_in}, 8'h00);
    dbg_swdio_oe = 1'b0; dbg_tdo_oe = 1'b0; dbg_tdo_out = 1'b0; dbg_swo_out = 1'b1;

    // R2 R4 R6 R7 release steps
    wr(4'h1, 1'b1, "R4");
    wr(4'h2, 1'b1, "R2");
    wr(4'h3, 1'b0, "R6");
    chk(gpio_in == ~FRC_LVL, "R9", "gpio_in released", {3'b0, gpio_in}, {3'b0, ~FRC_LVL});
    gpio_oe = 5'b11111; gpio_out = 5'b01100;
    #1;
    chk(pad_oe == 5'b11111 && pad_out == 5'b01100, "R9", "gpio drive",
        {3'b0, pad_out}, 8'h0c);
    gpio_oe = 5'b00000; gpio_out = 5'b00000;
    // R5 return all, no wait even if buffer full
    wr(4'h0, 1'b1, "R5");
    // R3 unused code acts as none
    wr(4'h6, 1'b1, "R3");
    // R8 trace on with pad 3 owned
    wr(4'h8, 1'b0, "R8");
    chk(pad_out[3] == 1'b1 && pad_oe[3] == 1'b1, "R8", "trace out",
        {6'b0, pad_out[3], pad_oe[3]}, 8'h03);
    // R8 trace on but pad 3 released: GPIO drives it
    wr(4'hA, 1'b1, "R8");
    chk(pad_out[3] == 1'b0 && pad_oe[3] == 1'b0, "R8", "trace released",
        {6'b0, pad_out[3], pad_oe[3]}, 8'h00);
    // R7 partial return with buffer full: no release, no wait
    wr(4'h1, 1'b1, "R7");

    repeat (4) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule